// File: doc/BRIEF.md
# Feedback Lock Detector with Missing-Clock Watchdog

This block turns a stream of per-cycle phase verdicts from a clock multiplier into a single lock flag. Each feedback cycle is signalled by a level change on a toggle line that comes from the feedback clock domain. A phase-error bit travels alongside the toggle and says whether the reference-to-feedback phase difference in that cycle exceeded the allowed propagation-delay window. Both signals are brought into the reference clock domain by a synchroniser. Every detected level change counts as one feedback cycle.

Two run counters give the flag asymmetric hysteresis. A short run of consecutive errored cycles clears the flag. A much longer run of consecutive clean cycles is needed to set it. A watchdog runs from a prescaled reference count and restarts on every feedback cycle. If the feedback stream stops while the flag is set, the watchdog clears the flag once its time-out expires. The flag is registered in the reference domain and feeds reset sequencing or status logic elsewhere on the chip.

Top module: `lock_detect`

## Requirements
- R1: During and after reset, and before any feedback cycle has arrived, `lockOut` is 0.
- R2: While unlocked, `lockOut` goes to 1 after 32 consecutive feedback cycles with `fbPhaseErr` = 0. A run of 31 such cycles leaves it at 0.
- R3: While unlocked, a feedback cycle with `fbPhaseErr` = 1 restarts the clean run from zero, so clean cycles before it do not count toward the 32.
- R4: While locked, the 4th consecutive feedback cycle with `fbPhaseErr` = 1 clears `lockOut`. One to three consecutive errored cycles leave it at 1.
- R5: While locked, a clean feedback cycle restarts the error run from zero, so errors before it do not count toward the 4.
- R6: While locked, a gap of 1024 reference cycles with no feedback cycle clears `lockOut`. This is 2^10, made of a 16-cycle prescaler and a 64-count watchdog. Any feedback cycle within the window restarts it, so feedback cycles 1000 reference cycles apart keep the lock.
- R7: After a watchdog time-out, 32 fresh consecutive clean feedback cycles are needed to relock. Clean cycles seen before the time-out do not count.
- R8: A feedback cycle is one change in level of `fbToggle`. `fbPhaseErr` is captured with it. `lockOut` reacts on the 3rd rising edge of `refClk` after the toggle changes: two synchroniser stages, then the counter-and-state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; all logic runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| fbToggle | input | 1 | Changes level once per feedback cycle (feedback domain) |
| fbPhaseErr | input | 1 | Phase-error verdict for the cycle marked by the toggle; 1 means outside the window |
| lockOut | output | 1 | Registered lock flag, 1 means locked |

## Verification
Clean runs of 30 to 33 cycles are swept from reset. This separates the exact gain threshold from off-by-one variants. Runs of clean cycles broken by a single error, and error runs of one to four broken by a clean cycle, show whether each counter restarts on the opposite verdict. A long silence while locked, preceded by a 1000-cycle gap that must not trip, pins the watchdog window from both sides. A relock attempt right after the time-out shows that stale clean history is discarded. A probe of the flag two and three edges after a toggle fixes the synchroniser latency.

// File: rtl/lock_detect_pkg.sv
package lock_detect_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_t;

  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic runsClear;  // zero both run counters
    logic wdogHold;   // hold watchdog at zero (not locked)
  } ctrl_strobe_t;

endpackage

// File: rtl/lock_detect_sync.sv
module lock_detect_sync #(
  parameter int STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic fbToggle,
  input  logic fbPhaseErr,
  output logic fbEvent,
  output logic fbErr
);

  logic [STAGES:0]   tglPipe;
  logic [STAGES-1:0] errPipe;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      tglPipe <= '0;
      errPipe <= '0;
    end else begin
      tglPipe <= {tglPipe[STAGES-1:0], fbToggle};
      errPipe <= {errPipe[STAGES-2:0], fbPhaseErr};
    end
  end

  // one synchronised level change marks one feedback cycle
  assign fbEvent = tglPipe[STAGES] ^ tglPipe[STAGES-1];
  assign fbErr   = errPipe[STAGES-1];

endmodule

// File: rtl/lock_detect_datapath.sv
module lock_detect_datapath
  import lock_detect_pkg::*;
#(
  parameter int DROP_COUNT = 4,
  parameter int GAIN_COUNT = 32,
  parameter int PRE_BITS   = 4,
  parameter int WDOG_BITS  = 6
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic         fbEvent,
  input  logic         fbErr,
  input  ctrl_strobe_t strobe,
  output logic         errRunHit,
  output logic         cleanRunHit,
  output logic         wdogExp
);

  localparam int ERR_W   = $clog2(DROP_COUNT + 1);
  localparam int CLEAN_W = $clog2(GAIN_COUNT + 1);
  localparam logic [ERR_W-1:0]   ERR_LAST   = ERR_W'(DROP_COUNT - 1);
  localparam logic [CLEAN_W-1:0] CLEAN_LAST = CLEAN_W'(GAIN_COUNT - 1);

  logic [ERR_W-1:0]     errRun;
  logic [CLEAN_W-1:0]   cleanRun;
  logic [PRE_BITS-1:0]  preCnt;
  logic [WDOG_BITS-1:0] wdogCnt;

  // run counters: each verdict restarts the opposite run
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      errRun   <= '0;
      cleanRun <= '0;
    end else if (strobe.runsClear) begin
      errRun   <= '0;
      cleanRun <= '0;
    end else if (fbEvent) begin
      if (fbErr) begin
        cleanRun <= '0;
        if (errRun != ERR_LAST) errRun <= errRun + 1'b1;
      end else begin
        errRun <= '0;
        if (cleanRun != CLEAN_LAST) cleanRun <= cleanRun + 1'b1;
      end
    end
  end

  assign errRunHit   = fbEvent &&  fbErr && (errRun == ERR_LAST);
  assign cleanRunHit = fbEvent && !fbErr && (cleanRun == CLEAN_LAST);

  // watchdog: prescaler feeding a count of prescaler wraps
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      wdogCnt <= '0;
    end else if (strobe.wdogHold || fbEvent) begin
      preCnt  <= '0;
      wdogCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (&preCnt) wdogCnt <= wdogCnt + 1'b1;
    end
  end

  assign wdogExp = !strobe.wdogHold && !fbEvent && (&preCnt) && (&wdogCnt);

endmodule

// File: rtl/lock_detect_ctrl.sv
module lock_detect_ctrl
  import lock_detect_pkg::*;
(
  input  logic         refClk,
  input  logic         rstN,
  input  logic         errRunHit,
  input  logic         cleanRunHit,
  input  logic         wdogExp,
  output ctrl_strobe_t strobe,
  output logic         lockOut
);

  lock_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_UNLOCKED: if (cleanRunHit)            stateNext = ST_LOCKED;
      ST_LOCKED:   if (errRunHit || wdogExp)   stateNext = ST_UNLOCKED;
      default:                                 stateNext = ST_UNLOCKED;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= ST_UNLOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.wdogHold  = (state == ST_UNLOCKED);
    strobe.runsClear = (state == ST_LOCKED) && wdogExp;
  end

  assign lockOut = (state == ST_LOCKED);

endmodule

// File: rtl/lock_detect.sv
module lock_detect
  import lock_detect_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DROP_COUNT  = 4,
  parameter int GAIN_COUNT  = 32,
  parameter int PRE_BITS    = 4,
  parameter int WDOG_BITS   = 6
) (
  input  logic refClk,
  input  logic rstN,
  input  logic fbToggle,
  input  logic fbPhaseErr,
  output logic lockOut
);

  logic         fbEvent;
  logic         fbErr;
  logic         errRunHit;
  logic         cleanRunHit;
  logic         wdogExp;
  ctrl_strobe_t strobe;

  lock_detect_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .refClk     (refClk),
    .rstN       (rstN),
    .fbToggle   (fbToggle),
    .fbPhaseErr (fbPhaseErr),
    .fbEvent    (fbEvent),
    .fbErr      (fbErr)
  );

  lock_detect_datapath #(
    .DROP_COUNT (DROP_COUNT),
    .GAIN_COUNT (GAIN_COUNT),
    .PRE_BITS   (PRE_BITS),
    .WDOG_BITS  (WDOG_BITS)
  ) u_dp (
    .refClk      (refClk),
    .rstN        (rstN),
    .fbEvent     (fbEvent),
    .fbErr       (fbErr),
    .strobe      (strobe),
    .errRunHit   (errRunHit),
    .cleanRunHit (cleanRunHit),
    .wdogExp     (wdogExp)
  );

  lock_detect_ctrl u_ctrl (
    .refClk      (refClk),
    .rstN        (rstN),
    .errRunHit   (errRunHit),
    .cleanRunHit (cleanRunHit),
    .wdogExp     (wdogExp),
    .strobe      (strobe),
    .lockOut     (lockOut)
  );

endmodule

// File: rtl/lock_detect_chk.sv
module lock_detect_chk (
  input logic refClk,
  input logic rstN,
  input logic lockOut,
  input logic fbEvent,
  input logic fbErr,
  input logic wdogExp
);

  // R2: the flag only rises on a clean feedback cycle
  a_r2_rise_on_clean: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockOut) |-> $past(fbEvent && !fbErr));

  // R4, R6: the flag only falls on an errored cycle or a watchdog expiry
  a_r4_fall_has_cause: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lockOut) |-> $past((fbEvent && fbErr) || wdogExp));

  // R5: a clean cycle while locked never drops the flag
  a_r5_clean_keeps_lock: assert property (@(posedge refClk) disable iff (!rstN)
    (lockOut && fbEvent && !fbErr) |=> lockOut);

  // R3: an errored cycle while unlocked never raises the flag
  a_r3_err_keeps_unlocked: assert property (@(posedge refClk) disable iff (!rstN)
    (!lockOut && fbEvent && fbErr) |=> !lockOut);

  // R6: the watchdog only expires while locked
  a_r6_wdog_when_locked: assert property (@(posedge refClk) disable iff (!rstN)
    wdogExp |-> lockOut);

  // R8: with no feedback cycle and no expiry the flag holds
  a_r8_stable_when_idle: assert property (@(posedge refClk) disable iff (!rstN)
    (!fbEvent && !wdogExp) |=> $stable(lockOut));

endmodule

bind lock_detect lock_detect_chk u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .lockOut (lockOut),
  .fbEvent (fbEvent),
  .fbErr   (fbErr),
  .wdogExp (wdogExp)
);

// File: tb/lock_detect_tb.sv
`timescale 1ns/1ps
module lock_detect_tb;

  localparam int GAP = 4;

  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic fbToggle = 1'b0;
  logic fbPhaseErr = 1'b0;
  logic lockOut;

  int nChecks = 0;
  int nFails  = 0;
  logic expLock;
  int errRunM;
  int cleanRunM;

  always #2 refClk = ~refClk;  // 250 MHz

  lock_detect u_dut (
    .refClk     (refClk),
    .rstN       (rstN),
    .fbToggle   (fbToggle),
    .fbPhaseErr (fbPhaseErr),
    .lockOut    (lockOut)
  );

  task automatic check(input string req, input logic exp);
    nChecks++;
    if (lockOut !== exp) begin
      nFails++;
      $display("FAIL %s: lockOut=%b expected=%b at %0t", req, lockOut, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fbToggle = 1'b0;
    fbPhaseErr = 1'b0;
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    rstN = 1'b1;
    expLock = 1'b0;
    errRunM = 0;
    cleanRunM = 0;
    repeat (2) @(posedge refClk);
    #1;
  endtask

  // one feedback cycle, model update from the requirements, then compare
  task automatic fbCycle(input logic err, input string req);
    @(negedge refClk);
    fbPhaseErr = err;
    fbToggle = ~fbToggle;
    repeat (GAP) @(posedge refClk);
    #1;
    if (err) begin
      errRunM++;
      cleanRunM = 0;
      if (expLock && errRunM >= 4) expLock = 1'b0;
    end else begin
      cleanRunM++;
      errRunM = 0;
      if (!expLock && cleanRunM >= 32) expLock = 1'b1;
    end
    check(req, expLock);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, lockOut=%b expected=done", lockOut);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (2) @(posedge refClk);
    #1;
    check("R1", 1'b0);
    doReset();
    check("R1", 1'b0);

    // R2: sweep clean run lengths around the threshold
    for (int n = 30; n <= 33; n++) begin
      doReset();
      for (int i = 0; i < n; i++) fbCycle(1'b0, "R2");
    end

    // R8: latency of the flag after the 32nd toggle change
    doReset();
    for (int i = 0; i < 31; i++) fbCycle(1'b0, "R8");
    @(negedge refClk);
    fbPhaseErr = 1'b0;
    fbToggle = ~fbToggle;
    repeat (2) @(posedge refClk);
    #1;
    check("R8", 1'b0);
    @(posedge refClk);
    #1;
    check("R8", 1'b1);

    // R3: an error breaks the clean run
    doReset();
    for (int i = 0; i < 31; i++) fbCycle(1'b0, "R3");
    fbCycle(1'b1, "R3");
    for (int i = 0; i < 31; i++) fbCycle(1'b0, "R3");
    fbCycle(1'b0, "R3");
    check("R3", 1'b1);

    // R4, R5: error runs while locked
    for (int k = 1; k <= 3; k++) fbCycle(1'b1, "R4");
    fbCycle(1'b0, "R5");
    for (int k = 1; k <= 3; k++) fbCycle(1'b1, "R5");
    check("R5", 1'b1);
    fbCycle(1'b1, "R4");
    check("R4", 1'b0);
    for (int k = 0; k < 3; k++) fbCycle(1'b1, "R4");

    // R6: relock, then gaps short of and past the window
    for (int i = 0; i < 32; i++) fbCycle(1'b0, "R6");
    check("R6", 1'b1);
    idle(995);
    check("R6", 1'b1);
    fbCycle(1'b0, "R6");   // next edge ~1000 cycles after the previous one
    idle(1020);
    check("R6", 1'b1);
    idle(5);
    check("R6", 1'b0);
    expLock = 1'b0;
    cleanRunM = 0;
    errRunM = 0;

    // R7: stale clean history is discarded
    for (int i = 0; i < 31; i++) fbCycle(1'b0, "R7");
    check("R7", 1'b0);
    fbCycle(1'b0, "R7");
    check("R7", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule